// File: doc/BRIEF.md
# Power Button Sleep Wake Controller

This block sets the system power state from an active-low power-button level and a bank of wake request lines. The button level is already synchronized and debounced. The controller tracks four states: running, sleeping, soft-off and unpowered. It returns the current state and a power-on request. It also drives single-cycle set and clear strobes for a status register that sits outside the block. That register returns the button-status flag to the controller as an input.

A seconds tick lets the controller measure how long the button is held. A hold of `HOLD_SECS` ticks, 4 by default, overrides the button press and forces the system to soft-off. After an override, only the button can wake the system. Power loss and power restoration arrive as pulses. On restoration, an option input chooses between resuming in the running state and staying in soft-off.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: Each time `btnN` goes from high to low, `setBtnSts` pulses for one cycle, in the cycle after the edge that first samples the low level. The enable inputs have no effect on this pulse, but no pulse occurs while the system is unpowered.
- R2: In the running state, if `btnEn` and `btnSts` are both set, the cycle after the sample raises `sciReq` when `sciEn` is 1, or `smiReq` when `sciEn` is 0. Neither request is raised from any other state, and the two are never raised together.
- R3: In the running state, `sleepGo` moves the state to sleeping on the next cycle.
- R4: While `btnN` stays low, the block counts ticks. The count restarts whenever the button is released. On the `HOLD_SECS`-th tick of one continuous press, `clrBtnSts`, `setOvrSts` and `setAfterFail` pulse together and the state becomes soft-off on the next cycle. This happens at most once per press, and it takes priority over sleep and wake. `HOLD_SECS` must be at least 2.
- R5: After an override, the `wakeReq` lines are ignored until the system next reaches the running state. The button still wakes the system.
- R6: In the sleeping or soft-off state, an enabled wake moves the state to running and pulses `setWakSts` on the next cycle. An enabled wake is either `btnEn` and `btnSts` both set, or any bit of `wakeReq & wakeEn`.
- R7: `pwrFail` moves the state to unpowered on the next cycle from any state. Loss of power outranks every other event and produces no strobe. While unpowered, every input except `pwrReturn` is ignored.
- R8: When `pwrReturn` arrives in the unpowered state, the next state is chosen as follows. If power was lost while sleeping, or `afterFailEn` is 1, the next state is soft-off. Otherwise the next state is running and `setWakSts` does not pulse.
- R9: The state is encoded on `pwrState` as running=0, sleeping=1, soft-off=2, unpowered=3. Reset puts the state in soft-off with all strobes and requests low. `pwrOn` is high exactly when the state is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| btnN | input | 1 | Synchronized power-button level, low while pressed |
| btnEn | input | 1 | Button event enable from the register file |
| btnSts | input | 1 | Current button-status flag from the register file |
| sciEn | input | 1 | Selects the SCI request (1) or the SMI request (0) |
| sleepGo | input | 1 | Sleep command pulse |
| wakeReq | input | NWAKE | Wake request lines |
| wakeEn | input | NWAKE | Per-line wake enables |
| afterFailEn | input | 1 | Stay in soft-off when power returns |
| pwrFail | input | 1 | Power-loss pulse |
| pwrReturn | input | 1 | Power-restore pulse |
| pwrState | output | 2 | Current state code |
| pwrOn | output | 1 | Power-on request |
| sciReq | output | 1 | SCI request |
| smiReq | output | 1 | SMI request |
| setBtnSts | output | 1 | Strobe that sets the button-status flag |
| clrBtnSts | output | 1 | Strobe that clears the button-status flag |
| setOvrSts | output | 1 | Strobe that sets the override-status flag |
| setWakSts | output | 1 | Strobe that sets the wake-status flag |
| setAfterFail | output | 1 | Strobe that sets the stay-off-after-power-loss option |

## Verification
Every output is a register, so each result appears exactly one clock after the edge that samples its cause. A state-status strobe from one cycle reaches the controller through `btnSts`, which the bench's register model updates from that strobe. The first cycle of a button press therefore sets the flag, and the second cycle acts on it. The bench drives inputs and compares outputs on the falling clock edge. Before each rising edge it advances its reference model with the same inputs, so every compare sees the results of exactly one rising edge. A held button overrides on the fourth tick-carrying cycle of the press.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    PS_ON      = 2'd0,
    PS_SLEEP   = 2'd1,
    PS_SOFTOFF = 2'd2,
    PS_NOPWR   = 2'd3
  } pwrState_e;

  // control -> datapath
  typedef struct packed {
    logic clrHold;
  } dpCtl_t;

  // datapath -> control
  typedef struct packed {
    logic fall;
    logic hold;
    logic srcWake;
    logic btnPend;
  } dpEvt_t;

  // flag strobes toward the status register
  typedef struct packed {
    logic setBtn;
    logic clrBtn;
    logic setOvr;
    logic setWak;
    logic setAfterFail;
  } flagStb_t;

endpackage

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int HOLD_SECS = 4,
  parameter int NWAKE     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             btnN,
  input  logic             btnEn,
  input  logic             btnSts,
  input  logic [NWAKE-1:0] wakeReq,
  input  logic [NWAKE-1:0] wakeEn,
  input  dpCtl_t           ctl,
  output dpEvt_t           evt
);

  localparam int CNT_W = $clog2(HOLD_SECS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HOLD_SECS - 1);

  logic             btnPrev;
  logic [CNT_W-1:0] holdCnt;
  logic             fired;
  logic             pressed;
  logic             lastTick;
  logic [NWAKE-1:0] hitVec;

  assign pressed  = ~btnN;
  assign lastTick = (holdCnt == LAST_CNT);

  // per-source wake match
  for (genvar g = 0; g < NWAKE; g++) begin : g_src
    assign hitVec[g] = wakeReq[g] & wakeEn[g];
  end

  assign evt.fall    = btnPrev & pressed & ~ctl.clrHold;
  assign evt.hold    = pressed & tick & ~fired & lastTick & ~ctl.clrHold;
  assign evt.srcWake = |hitVec;
  assign evt.btnPend = btnEn & btnSts;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      btnPrev <= 1'b1;
      holdCnt <= '0;
      fired   <= 1'b0;
    end else begin
      btnPrev <= btnN;
      if (ctl.clrHold || !pressed) begin
        holdCnt <= '0;
        fired   <= 1'b0;
      end else if (tick && !fired) begin
        if (lastTick) begin
          holdCnt <= '0;
          fired   <= 1'b1;
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import swc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepGo,
  input  logic      sciEn,
  input  logic      afterFailEn,
  input  logic      pwrFail,
  input  logic      pwrReturn,
  input  dpEvt_t    evt,
  output dpCtl_t    ctl,
  output pwrState_e state,
  output logic      pwrOn,
  output logic      sciReq,
  output logic      smiReq,
  output flagStb_t  stb
);

  pwrState_e nState;
  flagStb_t  nStb;
  logic      lock, nLock;
  logic      slp, nSlp;
  logic      wakeHit;

  assign ctl.clrHold = (state == PS_NOPWR);
  assign wakeHit     = evt.btnPend | (evt.srcWake & ~lock);

  always_comb begin
    nState = state;
    nStb   = '0;
    nLock  = lock;
    nSlp   = slp;
    if (state != PS_NOPWR && pwrFail) begin
      nState = PS_NOPWR;
      nSlp   = (state == PS_SLEEP);
    end else if (state == PS_NOPWR) begin
      if (pwrReturn) begin
        nState = (slp || afterFailEn) ? PS_SOFTOFF : PS_ON;
      end
    end else begin
      nStb.setBtn = evt.fall;
      if (evt.hold) begin
        nState            = PS_SOFTOFF;
        nStb.clrBtn       = 1'b1;
        nStb.setOvr       = 1'b1;
        nStb.setAfterFail = 1'b1;
        nLock             = 1'b1;
      end else if (state == PS_ON) begin
        if (sleepGo) nState = PS_SLEEP;
      end else if (wakeHit) begin
        nState      = PS_ON;
        nStb.setWak = 1'b1;
      end
    end
    if (nState == PS_ON) nLock = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= PS_SOFTOFF;
      stb    <= '0;
      lock   <= 1'b0;
      slp    <= 1'b0;
      pwrOn  <= 1'b0;
      sciReq <= 1'b0;
      smiReq <= 1'b0;
    end else begin
      state  <= nState;
      stb    <= nStb;
      lock   <= nLock;
      slp    <= nSlp;
      pwrOn  <= (nState == PS_ON);
      sciReq <= (state == PS_ON) && evt.btnPend && sciEn;
      smiReq <= (state == PS_ON) && evt.btnPend && !sciEn;
    end
  end

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int HOLD_SECS = 4,
  parameter int NWAKE     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             btnN,
  input  logic             btnEn,
  input  logic             btnSts,
  input  logic             sciEn,
  input  logic             sleepGo,
  input  logic [NWAKE-1:0] wakeReq,
  input  logic [NWAKE-1:0] wakeEn,
  input  logic             afterFailEn,
  input  logic             pwrFail,
  input  logic             pwrReturn,
  output logic [1:0]       pwrState,
  output logic             pwrOn,
  output logic             sciReq,
  output logic             smiReq,
  output logic             setBtnSts,
  output logic             clrBtnSts,
  output logic             setOvrSts,
  output logic             setWakSts,
  output logic             setAfterFail
);

  dpCtl_t    ctl;
  dpEvt_t    evt;
  flagStb_t  stb;
  pwrState_e state;

  swc_datapath #(.HOLD_SECS(HOLD_SECS), .NWAKE(NWAKE)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .btnN(btnN), .btnEn(btnEn),
    .btnSts(btnSts), .wakeReq(wakeReq), .wakeEn(wakeEn), .ctl(ctl), .evt(evt)
  );

  swc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sleepGo(sleepGo), .sciEn(sciEn),
    .afterFailEn(afterFailEn), .pwrFail(pwrFail), .pwrReturn(pwrReturn),
    .evt(evt), .ctl(ctl), .state(state), .pwrOn(pwrOn), .sciReq(sciReq),
    .smiReq(smiReq), .stb(stb)
  );

  assign pwrState     = state;
  assign setBtnSts    = stb.setBtn;
  assign clrBtnSts    = stb.clrBtn;
  assign setOvrSts    = stb.setOvr;
  assign setWakSts    = stb.setWak;
  assign setAfterFail = stb.setAfterFail;

endmodule

// File: rtl/swc_checker.sv
module swc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       btnN,
  input logic       pwrFail,
  input logic       pwrReturn,
  input logic [1:0] pwrState,
  input logic       pwrOn,
  input logic       sciReq,
  input logic       smiReq,
  input logic       setBtnSts,
  input logic       clrBtnSts,
  input logic       setOvrSts,
  input logic       setWakSts
);

  a_r1_fall_sets: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(btnN) && pwrState != 2'd3 && !pwrFail) |=> setBtnSts);

  a_r2_only_running: assert property (@(posedge clk) disable iff (!rstN)
    (sciReq || smiReq) |-> $past(pwrState) == 2'd0);

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sciReq && smiReq));

  a_r4_override_off: assert property (@(posedge clk) disable iff (!rstN)
    setOvrSts |-> (pwrState == 2'd2 && clrBtnSts));

  a_r4_single: assert property (@(posedge clk) disable iff (!rstN)
    setOvrSts |=> !setOvrSts);

  a_r6_wake_runs: assert property (@(posedge clk) disable iff (!rstN)
    setWakSts |-> (pwrState == 2'd0 && pwrOn));

  a_r7_fail_off: assert property (@(posedge clk) disable iff (!rstN)
    (pwrFail && pwrState != 2'd3) |=> pwrState == 2'd3);

  a_r7_stay_off: assert property (@(posedge clk) disable iff (!rstN)
    (pwrState == 2'd3 && !pwrReturn) |=> (pwrState == 2'd3 && !setBtnSts));

  a_r9_pwron: assert property (@(posedge clk) disable iff (!rstN)
    pwrOn |-> pwrState == 2'd0);

endmodule

bind sleep_wake_ctrl swc_checker u_chk (
  .clk(clk), .rstN(rstN), .btnN(btnN), .pwrFail(pwrFail),
  .pwrReturn(pwrReturn), .pwrState(pwrState), .pwrOn(pwrOn),
  .sciReq(sciReq), .smiReq(smiReq), .setBtnSts(setBtnSts),
  .clrBtnSts(clrBtnSts), .setOvrSts(setOvrSts), .setWakSts(setWakSts)
);

// File: tb/sleep_wake_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_tb;

  localparam int HOLD  = 4;
  localparam int NW    = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 0, btnN = 1, btnEn = 0, btnSts = 0, sciEn = 0, sleepGo = 0;
  logic [NW-1:0] wakeReq = '0, wakeEn = '0;
  logic afterFailEn = 0, pwrFail = 0, pwrReturn = 0;
  logic [1:0] pwrState;
  logic pwrOn, sciReq, smiReq, setBtnSts, clrBtnSts, setOvrSts, setWakSts, setAfterFail;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  logic [1:0] mState = 2'd2;
  logic mPrev = 1, mFired = 0, mLock = 0, mSlp = 0;
  int   mCnt = 0;
  logic [1:0] eState = 2'd2;
  logic ePwrOn = 0, eSci = 0, eSmi = 0;
  logic [4:0] eStb = '0;   // {setBtn, clrBtn, setOvr, setWak, setAfterFail}
  logic rBtnSts = 0;

  always #4 clk = ~clk;

  sleep_wake_ctrl #(.HOLD_SECS(HOLD), .NWAKE(NW)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .btnN(btnN), .btnEn(btnEn),
    .btnSts(btnSts), .sciEn(sciEn), .sleepGo(sleepGo), .wakeReq(wakeReq),
    .wakeEn(wakeEn), .afterFailEn(afterFailEn), .pwrFail(pwrFail),
    .pwrReturn(pwrReturn), .pwrState(pwrState), .pwrOn(pwrOn),
    .sciReq(sciReq), .smiReq(smiReq), .setBtnSts(setBtnSts),
    .clrBtnSts(clrBtnSts), .setOvrSts(setOvrSts), .setWakSts(setWakSts),
    .setAfterFail(setAfterFail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] nextState(input logic [1:0] st, input logic hold,
                                           input logic wake, input logic slp);
    if (st != 2'd3 && pwrFail) return 2'd3;
    if (st == 2'd3) return pwrReturn ? ((slp || afterFailEn) ? 2'd2 : 2'd0) : 2'd3;
    if (hold) return 2'd2;
    if (st == 2'd0) return sleepGo ? 2'd1 : 2'd0;
    return wake ? 2'd0 : st;
  endfunction

  // advance reference model by one rising edge using the driven inputs
  task automatic modelStep();
    logic inOff, pressed, fall, hold, pend, src, wake;
    logic [1:0] ns;
    inOff   = (mState == 2'd3);
    pressed = !btnN;
    fall    = mPrev && pressed && !inOff;
    hold    = pressed && tick && !mFired && (mCnt == HOLD - 1) && !inOff;
    pend    = btnEn && btnSts;
    src     = |(wakeReq & wakeEn);
    wake    = pend || (src && !mLock);
    ns      = nextState(mState, hold, wake, mSlp);
    eStb    = '0;
    if (!(mState != 2'd3 && pwrFail) && !inOff) begin
      eStb[4] = fall;
      if (hold) begin
        eStb[3] = 1; eStb[2] = 1; eStb[0] = 1; mLock = 1;
      end else if (mState != 2'd0 && wake) begin
        eStb[1] = 1;
      end
    end
    if (mState != 2'd3 && pwrFail) mSlp = (mState == 2'd1);
    eSci   = (mState == 2'd0) && pend && sciEn;
    eSmi   = (mState == 2'd0) && pend && !sciEn;
    ePwrOn = (ns == 2'd0);
    if (ns == 2'd0) mLock = 0;
    mPrev = btnN;
    if (inOff || !pressed) begin
      mCnt = 0; mFired = 0;
    end else if (tick && !mFired) begin
      if (mCnt == HOLD - 1) begin mCnt = 0; mFired = 1; end
      else mCnt++;
    end
    mState = ns;
    eState = ns;
  endtask

  // one cycle: inputs already set at a falling edge
  task automatic cyc(input bit swClr);
    if (swClr) rBtnSts = 0;
    btnSts = rBtnSts;
    modelStep();
    @(negedge clk);
    chk(pwrState == eState, "R3/R6/R7/R8 state", pwrState, eState);
    chk(pwrOn == ePwrOn, "R9 pwrOn", pwrOn, ePwrOn);
    chk(sciReq == eSci && smiReq == eSmi, "R2 sci/smi", {sciReq, smiReq}, {eSci, eSmi});
    chk({setBtnSts, clrBtnSts, setOvrSts, setWakSts, setAfterFail} == eStb,
        "R1/R4/R6 strobes", {setBtnSts, clrBtnSts, setOvrSts, setWakSts, setAfterFail}, eStb);
    if (eStb[3]) rBtnSts = 0;
    if (eStb[4]) rBtnSts = 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R9 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(pwrState == 2'd2, "R9 reset state", pwrState, 2);
    chk(!pwrOn && !setBtnSts && !setOvrSts && !setWakSts && !sciReq && !smiReq,
        "R9 reset outputs", pwrOn, 0);
    rstN = 1;

    // R1 + R6: press from soft-off wakes the system
    btnEn = 1; btnN = 0; cyc(0);
    chk(setBtnSts == 1, "R1 set on fall", setBtnSts, 1);
    cyc(0);
    chk(pwrState == 2'd0 && setWakSts, "R6 button wake", pwrState, 0);
    btnN = 1; cyc(1);

    // R2: requests in running state
    sciEn = 1; btnN = 0; cyc(0); cyc(0);
    chk(sciReq == 1, "R2 sci", sciReq, 1);
    sciEn = 0; cyc(0);
    chk(smiReq == 1 && !sciReq, "R2 smi", smiReq, 1);
    btnN = 1; cyc(1); cyc(0);

    // R3 sleep, R6 wake by source line
    sleepGo = 1; cyc(0); sleepGo = 0;
    chk(pwrState == 2'd1, "R3 sleep", pwrState, 1);
    idle(2);
    wakeEn = 4'b0010; wakeReq = 4'b0010; cyc(0); wakeReq = 0;
    chk(pwrState == 2'd0 && setWakSts, "R6 source wake", pwrState, 0);

    // R4 override on fourth tick, once per press
    tick = 1; btnN = 0; idle(3);
    chk(pwrState == 2'd0, "R4 not yet", pwrState, 0);
    cyc(0);
    chk(pwrState == 2'd2 && setOvrSts && clrBtnSts && setAfterFail, "R4 override", pwrState, 2);
    for (int i = 0; i < 6; i++) begin
      cyc(0);
      chk(!setOvrSts, "R4 once per press", setOvrSts, 0);
    end
    tick = 0; btnN = 1; cyc(1);

    // R5 source lines ignored after override, button still wakes
    wakeEn = 4'hF; wakeReq = 4'h4; idle(3);
    chk(pwrState == 2'd2, "R5 source ignored", pwrState, 2);
    wakeReq = 0; btnN = 0; cyc(0); cyc(0);
    chk(pwrState == 2'd0, "R5 button wakes", pwrState, 0);
    btnN = 1; cyc(1);

    // R4 restart on release
    tick = 1; btnN = 0; idle(3); btnN = 1; tick = 0; cyc(0);
    tick = 1; btnN = 0; idle(3);
    chk(pwrState == 2'd0, "R4 count restarts", pwrState, 0);
    tick = 0; btnN = 1; cyc(1); cyc(1);

    // R7 power loss, R8 return options
    pwrFail = 1; cyc(0); pwrFail = 0;
    chk(pwrState == 2'd3, "R7 lost power", pwrState, 3);
    btnN = 0; cyc(0);
    chk(!setBtnSts && pwrState == 2'd3, "R7 ignored while off", setBtnSts, 0);
    btnN = 1; cyc(0);
    afterFailEn = 0; pwrReturn = 1; cyc(0); pwrReturn = 0;
    chk(pwrState == 2'd0 && !setWakSts, "R8 resume running", pwrState, 0);
    afterFailEn = 1; pwrFail = 1; cyc(0); pwrFail = 0; pwrReturn = 1; cyc(0); pwrReturn = 0;
    chk(pwrState == 2'd2, "R8 stay off", pwrState, 2);
    btnN = 0; cyc(0); cyc(0); btnN = 1; cyc(1);
    sleepGo = 1; cyc(0); sleepGo = 0; afterFailEn = 0;
    pwrFail = 1; cyc(0); pwrFail = 0; pwrReturn = 1; cyc(0); pwrReturn = 0;
    chk(pwrState == 2'd2, "R8 slept then lost", pwrState, 2);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 19) == 0) btnN = ~btnN;
      tick      = ($urandom_range(0, 3) == 0);
      sleepGo   = ($urandom_range(0, 29) == 0);
      wakeReq   = ($urandom_range(0, 24) == 0) ? NW'($urandom) : '0;
      pwrFail   = ($urandom_range(0, 299) == 0);
      pwrReturn = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 49) == 0) begin
        btnEn = $urandom; sciEn = $urandom; afterFailEn = $urandom; wakeEn = NW'($urandom);
      end
      cyc($urandom_range(0, 9) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule